// File: doc/BRIEF.md
# Dispatch Resource Allocator with Rollback

This block moves one decoded instruction per clock from a valid/ready input into the back-end tracking structures. It reserves a reorder-buffer slot first. It then checks that a dependence-chain resource is available. After that it takes an issue-queue slot and a load/store-queue slot as the instruction class requires. All reservation and undo decisions are combinational within one cycle. If any later stage refuses, every grant already given in that cycle is withdrawn with a matching release pulse. The instruction is then held at the input so it retries on the next cycle.

Three classes of instruction exist. A plain op takes a reorder-buffer slot and an issue-queue slot. A load or store takes an issue-queue slot for its address computation and a load/store-queue slot for the access itself, and the two get consecutive sequence numbers. A memory barrier bypasses the issue queue and goes only to the load/store queue. The block also keeps the dispatch sequence counter, the free integer and floating-point physical-register counts, a dispatched-operation count and a count of chain-exhaustion stalls.

Top module: `dispatch_alloc`

## Requirements
- R1: Nothing is requested from any queue unless the destination counts fit the free physical-register counts. The reorder buffer is granted first (`rob_alloc_o` = fit and `rob_avail_i`). No issue-queue or load/store-queue grant appears unless the reorder buffer was granted and `chain_avail_i` is high.
- R2: When the reorder buffer is granted but `chain_avail_i` is low, `rob_release_o` pulses in the same cycle, no other grant is given, and `chain_stall_count_o` rises by one at the next edge.
- R3: For a non-barrier instruction whose issue-queue slot is refused (`iq_avail_i` low), the reorder buffer is released, no load/store-queue grant is given and the input stalls.
- R4: A barrier (`in_barrier_i` high) never takes an issue-queue slot. It succeeds when the reorder buffer, the chain resource and the load/store queue are all available. It reports `rob_ea_pend_o` low. `in_barrier_i` overrides `in_mem_i`.
- R5: A load/store (`in_mem_i` high, `in_barrier_i` low) gets `iq_seq_o` = N and `lsq_seq_o` = N+1. Its reorder-buffer entry carries `rob_seq_o` = N+1 and `rob_ea_pend_o` high. For a plain op, `rob_seq_o` = N.
- R6: When a load/store's load/store-queue slot is refused after its issue-queue grant, `iq_squash_o` and `rob_release_o` pulse in that same cycle and the input stalls.
- R7: On each successful dispatch, the sequence number N (visible on `iq_seq_o`) advances by 2 for loads, stores and barriers and by 1 for plain ops, wrapping modulo 2^SEQ_W.
- R8: On success, the integer and FP destination counts are subtracted from `free_int_o` and `free_fp_o`.
- R9: A destination count larger than the matching free count stalls the instruction with no grant. A count exactly equal to the free count is accepted.
- R10: On success, `op_count_o` rises by 2 for a load/store and by 1 for a plain op or a barrier.
- R11: `in_ready_o` is high exactly when dispatch succeeds. A failed or idle cycle leaves the sequence number, the free counts and `op_count_o` unchanged.
- R12: After reset, the sequence number and both event counts are 0, the free counts equal NUM_INT_PREG and NUM_FP_PREG, and with `in_valid_i` low no grant is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Instruction present |
| in_ready_o | output | 1 | Instruction dispatched this cycle |
| in_mem_i | input | 1 | Instruction is a load or store |
| in_barrier_i | input | 1 | Instruction is a memory barrier |
| in_int_dst_i | input | DST_W | Integer destination register count |
| in_fp_dst_i | input | DST_W | FP destination register count |
| chain_avail_i | input | 1 | Dependence-chain resource available |
| rob_avail_i | input | 1 | Reorder buffer has a free slot |
| rob_alloc_o | output | 1 | Reorder-buffer slot taken |
| rob_release_o | output | 1 | Reorder-buffer slot given back (rollback) |
| rob_seq_o | output | SEQ_W | Sequence number for the reorder-buffer entry |
| rob_ea_pend_o | output | 1 | Entry awaits an address computation |
| iq_avail_i | input | 1 | Issue queue has a free slot |
| iq_alloc_o | output | 1 | Issue-queue slot taken |
| iq_squash_o | output | 1 | Issue-queue slot and its links dropped (rollback) |
| iq_seq_o | output | SEQ_W | Current sequence number N, used by the issue-queue entry |
| lsq_avail_i | input | 1 | Load/store queue has a free slot |
| lsq_alloc_o | output | 1 | Load/store-queue slot taken |
| lsq_seq_o | output | SEQ_W | Sequence number for the load/store-queue entry |
| free_int_o | output | PREG_W | Free integer physical registers |
| free_fp_o | output | PREG_W | Free FP physical registers |
| op_count_o | output | CNT_W | Dispatched operation count |
| chain_stall_count_o | output | CNT_W | Chain-exhaustion stall count |

## Verification
The hardest case to reach is a load/store whose issue-queue grant must be undone because the load/store queue refuses it. That case needs the reorder buffer, the chain resource and the issue queue all willing while only the load/store queue is full. The bench sweeps every combination of the four availability inputs against all four class-flag encodings, so this case occurs on every pass. Register-limit stalls and the exact-fit boundary are reached by draining the free counts with maximal destination counts. Sequence wrap-around is reached by a long run of zero-destination memory ops.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;
  typedef enum logic [1:0] {
    CLS_PLAIN   = 2'd0,
    CLS_MEM     = 2'd1,
    CLS_BARRIER = 2'd2
  } disp_cls_e;

  function automatic disp_cls_e cls_decode(input logic mem, input logic barrier);
    if (barrier) return CLS_BARRIER;
    if (mem) return CLS_MEM;
    return CLS_PLAIN;
  endfunction
endpackage

// File: rtl/dispatch_alloc_ctl.sv
module dispatch_alloc_ctl
  import dispatch_pkg::*;
(
  input  logic      valid_i,
  input  logic      regs_ok_i,
  input  disp_cls_e cls_i,
  input  logic      rob_avail_i,
  input  logic      chain_avail_i,
  input  logic      iq_avail_i,
  input  logic      lsq_avail_i,
  output logic      rob_take_o,
  output logic      rob_undo_o,
  output logic      iq_take_o,
  output logic      iq_undo_o,
  output logic      lsq_take_o,
  output logic      chain_miss_o,
  output logic      done_o
);
  logic need_iq, need_lsq, chain_ok, iq_stage_ok, lsq_req;

  always_comb begin
    need_iq     = (cls_i != CLS_BARRIER);
    need_lsq    = (cls_i != CLS_PLAIN);
    rob_take_o  = valid_i && regs_ok_i && rob_avail_i;
    chain_miss_o = rob_take_o && !chain_avail_i;
    chain_ok    = rob_take_o && chain_avail_i;
    iq_take_o   = chain_ok && need_iq && iq_avail_i;
    iq_stage_ok = chain_ok && (!need_iq || iq_avail_i);
    lsq_req     = iq_stage_ok && need_lsq;
    lsq_take_o  = lsq_req && lsq_avail_i;
    done_o      = iq_stage_ok && (!need_lsq || lsq_avail_i);
    // undo every earlier grant when a later stage refuses
    iq_undo_o   = iq_take_o && lsq_req && !lsq_avail_i;
    rob_undo_o  = rob_take_o && !done_o;
  end
endmodule

// File: rtl/dispatch_seq_gen.sv
module dispatch_seq_gen #(
  parameter int SEQ_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             pair_i,
  output logic [SEQ_W-1:0] seq_o
);
  logic [SEQ_W-1:0] seq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seq_q <= '0;
    else if (adv_i) seq_q <= seq_q + (pair_i ? SEQ_W'(2) : SEQ_W'(1));
  end

  assign seq_o = seq_q;
endmodule

// File: rtl/dispatch_pool_cnt.sv
module dispatch_pool_cnt #(
  parameter int W     = 7,
  parameter int AMT_W = 2,
  parameter int INIT  = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic [AMT_W-1:0] amt_i,
  output logic             fit_o,
  output logic [W-1:0]     free_o
);
  logic [W-1:0] free_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) free_q <= W'(INIT);
    else if (take_i) free_q <= free_q - W'(amt_i);
  end

  assign fit_o  = (W'(amt_i) <= free_q);
  assign free_o = free_q;
endmodule

// File: rtl/dispatch_ev_cnt.sv
module dispatch_ev_cnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         dbl_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + (dbl_i ? W'(2) : W'(1));
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/dispatch_alloc.sv
module dispatch_alloc
  import dispatch_pkg::*;
#(
  parameter int SEQ_W        = 8,
  parameter int DST_W        = 2,
  parameter int PREG_W       = 7,
  parameter int NUM_INT_PREG = 48,
  parameter int NUM_FP_PREG  = 40,
  parameter int CNT_W        = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic              in_mem_i,
  input  logic              in_barrier_i,
  input  logic [DST_W-1:0]  in_int_dst_i,
  input  logic [DST_W-1:0]  in_fp_dst_i,
  input  logic              chain_avail_i,
  input  logic              rob_avail_i,
  output logic              rob_alloc_o,
  output logic              rob_release_o,
  output logic [SEQ_W-1:0]  rob_seq_o,
  output logic              rob_ea_pend_o,
  input  logic              iq_avail_i,
  output logic              iq_alloc_o,
  output logic              iq_squash_o,
  output logic [SEQ_W-1:0]  iq_seq_o,
  input  logic              lsq_avail_i,
  output logic              lsq_alloc_o,
  output logic [SEQ_W-1:0]  lsq_seq_o,
  output logic [PREG_W-1:0] free_int_o,
  output logic [PREG_W-1:0] free_fp_o,
  output logic [CNT_W-1:0]  op_count_o,
  output logic [CNT_W-1:0]  chain_stall_count_o
);
  localparam int NPOOL = 2;

  disp_cls_e               cls;
  logic                    done, chain_miss, regs_ok, paired;
  logic [SEQ_W-1:0]        seq;
  logic [NPOOL-1:0]        pool_fit;
  logic [NPOOL-1:0][DST_W-1:0]  pool_amt;
  logic [NPOOL-1:0][PREG_W-1:0] pool_free;

  assign cls         = cls_decode(in_mem_i, in_barrier_i);
  assign paired      = (cls != CLS_PLAIN);
  assign pool_amt[0] = in_int_dst_i;
  assign pool_amt[1] = in_fp_dst_i;
  assign regs_ok     = &pool_fit;

  for (genvar g = 0; g < NPOOL; g++) begin : g_pool
    dispatch_pool_cnt #(
      .W    (PREG_W),
      .AMT_W(DST_W),
      .INIT ((g == 0) ? NUM_INT_PREG : NUM_FP_PREG)
    ) pool_i (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .take_i(done),
      .amt_i (pool_amt[g]),
      .fit_o (pool_fit[g]),
      .free_o(pool_free[g])
    );
  end

  assign free_int_o = pool_free[0];
  assign free_fp_o  = pool_free[1];

  dispatch_alloc_ctl ctl_i (
    .valid_i      (in_valid_i),
    .regs_ok_i    (regs_ok),
    .cls_i        (cls),
    .rob_avail_i  (rob_avail_i),
    .chain_avail_i(chain_avail_i),
    .iq_avail_i   (iq_avail_i),
    .lsq_avail_i  (lsq_avail_i),
    .rob_take_o   (rob_alloc_o),
    .rob_undo_o   (rob_release_o),
    .iq_take_o    (iq_alloc_o),
    .iq_undo_o    (iq_squash_o),
    .lsq_take_o   (lsq_alloc_o),
    .chain_miss_o (chain_miss),
    .done_o       (done)
  );

  dispatch_seq_gen #(.SEQ_W(SEQ_W)) seq_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (done),
    .pair_i(paired),
    .seq_o (seq)
  );

  dispatch_ev_cnt #(.W(CNT_W)) ops_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (done),
    .dbl_i (cls == CLS_MEM),
    .cnt_o (op_count_o)
  );

  dispatch_ev_cnt #(.W(CNT_W)) chs_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (chain_miss),
    .dbl_i (1'b0),
    .cnt_o (chain_stall_count_o)
  );

  assign in_ready_o    = done;
  assign iq_seq_o      = seq;
  assign lsq_seq_o     = seq + SEQ_W'(1);
  // memory ops carry the access-side number in the reorder buffer
  assign rob_seq_o     = paired ? lsq_seq_o : seq;
  assign rob_ea_pend_o = (cls == CLS_MEM);
endmodule

// File: rtl/dispatch_alloc_chk.sv
module dispatch_alloc_chk #(
  parameter int SEQ_W  = 8,
  parameter int PREG_W = 7,
  parameter int CNT_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic              in_mem_i,
  input logic              in_barrier_i,
  input logic              chain_avail_i,
  input logic              rob_alloc_o,
  input logic              rob_release_o,
  input logic [SEQ_W-1:0]  rob_seq_o,
  input logic              iq_alloc_o,
  input logic              iq_squash_o,
  input logic [SEQ_W-1:0]  iq_seq_o,
  input logic              lsq_alloc_o,
  input logic [SEQ_W-1:0]  lsq_seq_o,
  input logic [PREG_W-1:0] free_int_o,
  input logic [PREG_W-1:0] free_fp_o,
  input logic [CNT_W-1:0]  op_count_o
);
  // R1
  grant_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iq_alloc_o || lsq_alloc_o) |-> (rob_alloc_o && chain_avail_i));
  // R2
  chain_rollback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rob_alloc_o && !chain_avail_i) |-> (rob_release_o && !iq_alloc_o && !lsq_alloc_o));
  // R4
  barrier_no_iq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_barrier_i) |-> !iq_alloc_o);
  // R5
  mem_seq_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iq_alloc_o && lsq_alloc_o) |-> (lsq_seq_o == iq_seq_o + SEQ_W'(1) && rob_seq_o == lsq_seq_o));
  // R6
  squash_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iq_squash_o |-> (iq_alloc_o && rob_release_o && !lsq_alloc_o && !in_ready_o));
  // R7
  seq_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_ready_o && (in_mem_i || in_barrier_i)) |=> (iq_seq_o - $past(iq_seq_o)) == SEQ_W'(2));
  // R11
  release_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rob_release_o |-> (rob_alloc_o && !in_ready_o));
  // R11
  hold_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_o |=> ($stable(iq_seq_o) && $stable(free_int_o) && $stable(free_fp_o) && $stable(op_count_o)));
endmodule

bind dispatch_alloc dispatch_alloc_chk #(
  .SEQ_W (SEQ_W),
  .PREG_W(PREG_W),
  .CNT_W (CNT_W)
) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .in_valid_i   (in_valid_i),
  .in_ready_o   (in_ready_o),
  .in_mem_i     (in_mem_i),
  .in_barrier_i (in_barrier_i),
  .chain_avail_i(chain_avail_i),
  .rob_alloc_o  (rob_alloc_o),
  .rob_release_o(rob_release_o),
  .rob_seq_o    (rob_seq_o),
  .iq_alloc_o   (iq_alloc_o),
  .iq_squash_o  (iq_squash_o),
  .iq_seq_o     (iq_seq_o),
  .lsq_alloc_o  (lsq_alloc_o),
  .lsq_seq_o    (lsq_seq_o),
  .free_int_o   (free_int_o),
  .free_fp_o    (free_fp_o),
  .op_count_o   (op_count_o)
);

// File: tb/dispatch_alloc_tb.sv
module dispatch_alloc_tb_top;
  localparam int NI = 48;
  localparam int NF = 40;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       in_valid_i = 1'b0, in_mem_i = 1'b0, in_barrier_i = 1'b0;
  logic [1:0] in_int_dst_i = '0, in_fp_dst_i = '0;
  logic       chain_avail_i = 1'b0, rob_avail_i = 1'b0, iq_avail_i = 1'b0, lsq_avail_i = 1'b0;
  logic       in_ready_o, rob_alloc_o, rob_release_o, rob_ea_pend_o;
  logic       iq_alloc_o, iq_squash_o, lsq_alloc_o;
  logic [7:0] rob_seq_o, iq_seq_o, lsq_seq_o;
  logic [6:0] free_int_o, free_fp_o;
  logic [15:0] op_count_o, chain_stall_count_o;

  int n_chk = 0, n_fail = 0;
  logic [7:0] m_seq = '0;
  int m_int = NI, m_fp = NF, m_ops = 0, m_chs = 0;

  always #4 clk_i = ~clk_i;

  dispatch_alloc #(.NUM_INT_PREG(NI), .NUM_FP_PREG(NF)) dut_i (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_state();
    chk(iq_seq_o == m_seq, "R7 seq", iq_seq_o, m_seq);
    chk(free_int_o == m_int, "R8 free_int", free_int_o, m_int);
    chk(free_fp_o == m_fp, "R8 free_fp", free_fp_o, m_fp);
    chk(op_count_o == m_ops, "R10 op_count", op_count_o, m_ops);
    chk(chain_stall_count_o == m_chs, "R2 chain_stall", chain_stall_count_o, m_chs);
  endtask

  task automatic step(input bit v, input logic [1:0] cls, input bit ra, input bit co,
                      input bit ia, input bit la, input int id, input int fd);
    bit memc, bar, need, rok, e_rob, e_go, e_iq, e_lreq, e_lsq, e_ok, e_rel, e_sq;
    @(negedge clk_i);
    chk_state();
    in_valid_i = v; in_mem_i = cls[0]; in_barrier_i = cls[1];
    rob_avail_i = ra; chain_avail_i = co; iq_avail_i = ia; lsq_avail_i = la;
    in_int_dst_i = 2'(id); in_fp_dst_i = 2'(fd);
    #1;
    bar  = cls[1];
    memc = cls[0] && !bar;
    need = memc || bar;
    rok  = (id <= m_int) && (fd <= m_fp);
    e_rob  = v && rok && ra;
    e_go   = e_rob && co;
    e_iq   = e_go && !bar && ia;
    e_lreq = e_go && need && (bar || ia);
    e_lsq  = e_lreq && la;
    e_ok   = e_go && (bar || ia) && (!need || la);
    e_rel  = e_rob && !e_ok;
    e_sq   = e_iq && memc && !la;
    chk(rob_alloc_o == e_rob, "R1/R9 rob_alloc", rob_alloc_o, e_rob);
    chk(iq_alloc_o == e_iq, "R1/R3/R4 iq_alloc", iq_alloc_o, e_iq);
    chk(lsq_alloc_o == e_lsq, "R1/R4 lsq_alloc", lsq_alloc_o, e_lsq);
    chk(in_ready_o == e_ok, "R11 ready", in_ready_o, e_ok);
    chk(rob_release_o == e_rel, "R2/R3 rob_release", rob_release_o, e_rel);
    chk(iq_squash_o == e_sq, "R6 iq_squash", iq_squash_o, e_sq);
    if (e_rob) begin
      chk(rob_seq_o == (need ? m_seq + 8'd1 : m_seq), "R5 rob_seq", rob_seq_o,
          need ? m_seq + 8'd1 : m_seq);
      chk(rob_ea_pend_o == memc, "R4/R5 ea_pend", rob_ea_pend_o, memc);
    end
    if (e_lsq) chk(lsq_seq_o == m_seq + 8'd1, "R5 lsq_seq", lsq_seq_o, m_seq + 8'd1);
    @(posedge clk_i);
    if (e_ok) begin
      m_seq = m_seq + (need ? 8'd2 : 8'd1);
      m_int -= id; m_fp -= fd;
      m_ops += memc ? 2 : 1;
    end
    if (e_rob && !co) m_chs++;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R12 reset state, idle
    step(1'b0, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 0, 0);
    chk(rob_alloc_o == 1'b0 && in_ready_o == 1'b0, "R12 idle", rob_alloc_o, 0);
    // exhaustive availability x class sweep
    for (int p = 0; p < 4; p++)
      for (int c = 0; c < 4; c++)
        for (int a = 0; a < 16; a++)
          step(1'b1, 2'(c), a[3], a[2], a[1], a[0], (a + p) % 4, (a + c) % 3);
    // R9 drain integer registers, then the exact-fit boundary
    for (int k = 0; k < 25; k++) step(1'b1, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 3, 0);
    step(1'b1, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, m_int, 0);
    step(1'b1, 2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 1, 0);
    for (int k = 0; k < 25; k++) step(1'b1, 2'd2, 1'b1, 1'b1, 1'b1, 1'b1, 0, 3);
    step(1'b1, 2'd2, 1'b1, 1'b1, 1'b1, 1'b1, 0, m_fp);
    step(1'b1, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 0, 2);
    // R7 sequence wrap with zero-destination ops
    for (int k = 0; k < 140; k++) step(1'b1, 2'(k % 3), 1'b1, 1'b1, 1'b1, 1'b1, 0, 0);
    step(1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 0);
    @(negedge clk_i);
    chk_state();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule